// File: doc/BRIEF.md
# Counting Bloom Filter Lockset Register

This block keeps the set of locks a single thread currently holds, encoded as a 16-bit Bloom filter. The filter is divided into four parts of four bits. Each lock address is hashed once per part, and each hash picks one bit inside that part. The 16-bit vector goes to the candidate-set logic, which intersects it with per-variable candidate sets.

A plain Bloom filter cannot forget a key. To make release possible, every filter bit has a saturating 2-bit counter. The counter tracks how many held locks map onto that bit. An acquire increments the counters of the selected bits. A release decrements them, and a filter bit clears only when its counter reaches zero, so the other held locks that share the bit keep it set. If a counter would pass its ceiling, a sticky overflow flag is raised. A release aimed at a bit whose count is already zero is rejected as a whole and raises a sticky underflow flag.

Commands arrive on one valid/kind/address channel and complete in one cycle. The results show on the registered outputs after the next rising clock edge.

Top module: `lbf_lockset_reg`

## Requirements
- R1: A synchronous active-high reset clears all 16 filter bits, all 16 counters and both flags. Right after reset `filter_o` is 0 and `ovf_o` and `unf_o` are 0.
- R2: For part p (0..3), the position of the selected bit inside the part is `cmd_addr[2p+3:2p+2]`. The selected filter bit is `filter_o[4p + position]`.
- R3: An acquire (`cmd_valid`=1, `cmd_release`=0) sets the selected bit of every part in `filter_o`, visible one clock edge later.
- R4: An acquire whose selected bit is already set raises that bit's counter by one. A bit that is set for the first time gets a count of 1.
- R5: A release (`cmd_valid`=1, `cmd_release`=1) lowers the counter of each selected bit by one. A filter bit clears in the same cycle its counter reaches zero, and it stays set while its count is above zero.
- R6: A counter saturates at 3. An acquire that would raise any selected counter above 3 leaves that counter at 3, still updates the other selected counters, and sets `ovf_o`. `ovf_o` stays set until reset.
- R7: A release in which any selected counter is already 0 changes no filter bit and no counter, and sets `unf_o`. `unf_o` stays set until reset.
- R8: While `cmd_valid` is 0, the filter, the counters and the flags keep their values.
- R9: A command never changes a filter bit or counter that is not one of its four selected bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_release | input | 1 | Command kind: 0 acquire, 1 release |
| cmd_addr | input | 32 | Lock address to hash |
| filter_o | output | 16 | Registered lockset filter vector |
| ovf_o | output | 1 | Sticky counter saturation flag |
| unf_o | output | 1 | Sticky rejected-release flag |

## Verification
On every cycle the assertions check the following: the cleared state after reset, that both flags stay set once raised, that idle cycles leave the filter unchanged, that an acquire never clears a bit and leaves at least one set bit in each part, and that a release never sets a bit. Exact counter values cannot be seen at the ports. They are shown only by the bench's scenarios: shared bits that survive the release of one lock, a saturated lock that clears after three releases, and a random mix of acquires and releases over a small pool of colliding addresses, compared against a reference count model. The all-or-nothing rejection of an underflowing release is also shown only by those scenarios.

// File: rtl/lbf_pkg.sv
package lbf_pkg;
  typedef enum logic {
    CMD_ACQUIRE = 1'b0,
    CMD_RELEASE = 1'b1
  } lbf_cmd_e;
endpackage

// File: rtl/lbf_hash.sv
// Maps a lock address to one selected bit per filter part (one-hot within each part).
module lbf_hash #(
  parameter int ADDR_W    = 32,
  parameter int NUM_PARTS = 4,
  parameter int SEL_W     = 2,
  parameter int ADDR_LSB  = 2,
  localparam int PART_BITS = 1 << SEL_W,
  localparam int FILT_W    = NUM_PARTS * PART_BITS
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [FILT_W-1:0] sel
);
  always_comb begin
    sel = '0;
    for (int p = 0; p < NUM_PARTS; p++) begin
      sel[p*PART_BITS + int'(addr[ADDR_LSB + p*SEL_W +: SEL_W])] = 1'b1;
    end
  end
endmodule

// File: rtl/lbf_cnt_cell.sv
// One filter bit with its saturating occupancy counter.
module lbf_cnt_cell #(
  parameter int CNT_W = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic inc,
  input  logic dec,
  output logic bit_o,
  output logic at_zero,
  output logic at_max
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt;

  assign at_zero = (cnt == '0);
  assign at_max  = (cnt == CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      bit_o <= 1'b0;
    end else if (inc) begin
      if (!at_max) cnt <= cnt + CNT_ONE;
      bit_o <= 1'b1;
    end else if (dec && !at_zero) begin
      cnt <= cnt - CNT_ONE;
      if (cnt == CNT_ONE) bit_o <= 1'b0;
    end
  end
endmodule

// File: rtl/lbf_lockset_reg.sv
module lbf_lockset_reg #(
  parameter int ADDR_W    = 32,
  parameter int NUM_PARTS = 4,
  parameter int SEL_W     = 2,
  parameter int ADDR_LSB  = 2,
  parameter int CNT_W     = 2,
  localparam int PART_BITS = 1 << SEL_W,
  localparam int FILT_W    = NUM_PARTS * PART_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic              cmd_release,
  input  logic [ADDR_W-1:0] cmd_addr,
  output logic [FILT_W-1:0] filter_o,
  output logic              ovf_o,
  output logic              unf_o
);
  import lbf_pkg::*;

  logic [FILT_W-1:0] sel, zero_vec, max_vec, inc_vec, dec_vec;
  logic is_acq, is_rel, zero_hit, max_hit, rel_ok;

  lbf_hash #(
    .ADDR_W(ADDR_W), .NUM_PARTS(NUM_PARTS), .SEL_W(SEL_W), .ADDR_LSB(ADDR_LSB)
  ) i_hash (
    .addr(cmd_addr),
    .sel (sel)
  );

  assign is_acq   = cmd_valid && (lbf_cmd_e'(cmd_release) == CMD_ACQUIRE);
  assign is_rel   = cmd_valid && (lbf_cmd_e'(cmd_release) == CMD_RELEASE);
  assign zero_hit = |(sel & zero_vec);
  assign max_hit  = |(sel & max_vec);
  assign rel_ok   = is_rel && !zero_hit;
  assign inc_vec  = is_acq ? sel : '0;
  assign dec_vec  = rel_ok ? sel : '0;

  for (genvar b = 0; b < FILT_W; b++) begin : g_cell
    lbf_cnt_cell #(.CNT_W(CNT_W)) i_cell (
      .clk    (clk),
      .rst    (rst),
      .inc    (inc_vec[b]),
      .dec    (dec_vec[b]),
      .bit_o  (filter_o[b]),
      .at_zero(zero_vec[b]),
      .at_max (max_vec[b])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_o <= 1'b0;
      unf_o <= 1'b0;
    end else begin
      if (is_acq && max_hit) ovf_o <= 1'b1;
      if (is_rel && zero_hit) unf_o <= 1'b1;
    end
  end
endmodule

// File: rtl/lbf_lockset_chk.sv
module lbf_lockset_chk #(
  parameter int NUM_PARTS = 4,
  parameter int PART_BITS = 4,
  localparam int FILT_W = NUM_PARTS * PART_BITS
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic              cmd_release,
  input logic [FILT_W-1:0] filter_o,
  input logic              ovf_o,
  input logic              unf_o
);
  logic [NUM_PARTS-1:0] part_nonempty;
  always_comb begin
    for (int p = 0; p < NUM_PARTS; p++)
      part_nonempty[p] = |filter_o[p*PART_BITS +: PART_BITS];
  end

  a_r1_reset_clear: assert property (@(posedge clk)
    $past(rst) |-> (filter_o == '0 && !ovf_o && !unf_o));

  a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ovf_o)) |-> ovf_o);

  a_r7_unf_sticky: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(unf_o)) |-> unf_o);

  a_r8_idle_stable: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(cmd_valid)) |-> ($stable(filter_o) && $stable(ovf_o) && $stable(unf_o)));

  a_r3_acquire_sets: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cmd_valid) && !$past(cmd_release))
      |-> (((filter_o & $past(filter_o)) == $past(filter_o)) && (&part_nonempty)));

  a_r5_release_no_set: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cmd_valid) && $past(cmd_release))
      |-> ((filter_o & ~$past(filter_o)) == '0));
endmodule

bind lbf_lockset_reg lbf_lockset_chk #(
  .NUM_PARTS(NUM_PARTS), .PART_BITS(PART_BITS)
) i_lbf_lockset_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_release(cmd_release),
  .filter_o(filter_o), .ovf_o(ovf_o), .unf_o(unf_o)
);

// File: tb/test_lbf_lockset_reg.sv
module test_lbf_lockset_reg;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic        cmd_release = 1'b0;
  logic [31:0] cmd_addr = '0;
  logic [15:0] filter_o;
  logic        ovf_o, unf_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  int          m_cnt [16];
  logic        m_ovf, m_unf;

  always #(CLK_PERIOD/2) clk = ~clk;

  lbf_lockset_reg i_lbf_lockset_reg (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_release(cmd_release),
    .cmd_addr(cmd_addr), .filter_o(filter_o), .ovf_o(ovf_o), .unf_o(unf_o)
  );

  function automatic int sel_idx(logic [31:0] a, int p);
    return 4*p + int'(a[2*p+2 +: 2]);
  endfunction

  function automatic logic [15:0] model_filter();
    logic [15:0] f;
    for (int b = 0; b < 16; b++) f[b] = (m_cnt[b] != 0);
    return f;
  endfunction

  task automatic check(string tag);
    checks++;
    if (filter_o !== model_filter() || ovf_o !== m_ovf || unf_o !== m_unf) begin
      errors++;
      $display("FAIL %s: filter=%h ovf=%b unf=%b expected filter=%h ovf=%b unf=%b",
               tag, filter_o, ovf_o, unf_o, model_filter(), m_ovf, m_unf);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; cmd_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int b = 0; b < 16; b++) m_cnt[b] = 0;
    m_ovf = 1'b0; m_unf = 1'b0;
    check("R1 reset state");
  endtask

  task automatic do_cmd(bit rel, logic [31:0] a, string tag);
    bit any_zero;
    cmd_valid = 1'b1; cmd_release = rel; cmd_addr = a;
    if (!rel) begin
      for (int p = 0; p < 4; p++)
        if (m_cnt[sel_idx(a, p)] == 3) m_ovf = 1'b1;
        else m_cnt[sel_idx(a, p)]++;
    end else begin
      any_zero = 0;
      for (int p = 0; p < 4; p++) if (m_cnt[sel_idx(a, p)] == 0) any_zero = 1;
      if (any_zero) m_unf = 1'b1;
      else for (int p = 0; p < 4; p++) m_cnt[sel_idx(a, p)]--;
    end
    @(negedge clk);
    cmd_valid = 1'b0;
    check(tag);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      cmd_addr = $urandom; cmd_release = $urandom;
      @(negedge clk);
      check("R8 idle hold");
    end
  endtask

  localparam logic [31:0] LOCK_A = 32'h0000_0000;
  localparam logic [31:0] LOCK_B = 32'h0000_00E4;

  initial begin
    logic [31:0] pool [6];
    void'($urandom(32'd4242));
    do_reset();

    do_cmd(0, LOCK_A, "R2 R3 acquire A");
    checks++;
    if (filter_o !== 16'h1111) begin
      errors++; $display("FAIL R2: filter=%h expected 1111", filter_o);
    end
    do_cmd(0, LOCK_B, "R3 R4 acquire B sharing bit 12");
    checks++;
    if (filter_o !== 16'h1953) begin
      errors++; $display("FAIL R2: filter=%h expected 1953", filter_o);
    end
    do_cmd(1, LOCK_A, "R5 R9 release A keeps shared bit");
    do_cmd(1, LOCK_A, "R7 release of unheld A rejected");
    idle(3);
    do_cmd(1, LOCK_B, "R5 release B clears all");

    do_reset();
    for (int i = 0; i < 3; i++) do_cmd(0, LOCK_B, "R4 repeated acquire");
    do_cmd(0, LOCK_B, "R6 saturating acquire");
    do_cmd(0, LOCK_A, "R6 R4 partial saturation at bit 12");
    for (int i = 0; i < 2; i++) do_cmd(1, LOCK_B, "R5 release saturated B");
    do_cmd(1, LOCK_B, "R5 R6 bit 12 shared, B bits cleared");
    do_cmd(1, LOCK_B, "R7 over-release of B");
    idle(2);

    do_reset();
    pool[0] = LOCK_A; pool[1] = LOCK_B; pool[2] = 32'h0000_0154;
    pool[3] = 32'h0000_03FC; pool[4] = 32'h0000_0010; pool[5] = 32'h0000_0244;
    for (int i = 0; i < 600; i++) begin
      int k = int'($urandom % 6);
      int r = int'($urandom % 10);
      if (r < 5)      do_cmd(0, pool[k], "R3 R4 R6 random acquire");
      else if (r < 9) do_cmd(1, pool[k], "R5 R7 R9 random release");
      else            idle(1);
      if (i == 300) do_reset();
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule